// File: doc/BRIEF.md
# Packed Shift, Pack and Unpack Unit

This block performs the lane-rearranging operations of a 64-bit packed-integer datapath. It shifts every lane of the destination operand left or right, logically or arithmetically, at a chosen lane size. The shift count comes either from the full 64-bit source operand or from an 8-bit immediate.

It also narrows lanes with saturation. Signed doublewords become signed words, and signed words become signed or unsigned bytes. It widens data by interleaving the lower or upper halves of the destination and source operands.

An operation starts when `start_i` is high on a rising clock edge. One cycle later the registered result appears together with a single-cycle `done_o` pulse. When the operation and lane-size combination is not supported, `illegal_o` is raised in the same cycle. Instruction decode and register-file access are the job of the surrounding pipeline.

Top module: `pkrearr_unit`

## Requirements
- R1: A start sampled high on a rising edge gives `done_o` high for exactly the following cycle, with `result_o` and `illegal_o` updated on that same edge. Back-to-back starts give one result per cycle.
- R2: While `start_i` is low, `result_o` holds its last value and `done_o` stays low.
- R3: `op_i` 0 is a logical left shift and 1 is a logical right shift of each lane of `dst_i`. The lane size comes from `gran_i` (0 byte, 1 word, 2 doubleword, 3 quadword). The count is `imm_i` when `use_imm_i` is 1, otherwise the whole 64-bit `src_i`.
- R4: A shift count at or above the lane width yields zero for logical shifts and the lane's sign bit in every position for arithmetic shifts.
- R5: `op_i` 2 is an arithmetic right shift of each lane, replicating the lane's top bit.
- R6: Shifts at byte size, arithmetic shift at quadword size and unpacks at quadword size are unsupported. Each raises `illegal_o` with `done_o` and gives a zero result.
- R7: `op_i` 3 narrows each signed 32-bit lane to a signed 16-bit lane with saturation (limits 0x7FFF and 0x8000). Converted `dst_i` lanes fill bits 31:0 and converted `src_i` lanes fill bits 63:32, with lane order kept.
- R8: `op_i` 4 narrows each signed 16-bit lane to a signed byte with saturation (limits 0x7F and 0x80). `dst_i` goes to bits 31:0 and `src_i` to bits 63:32.
- R9: `op_i` 5 narrows each signed 16-bit lane to an unsigned byte. Negative values become 0x00 and values above 255 become 0xFF, with the same placement as R8.
- R10: `op_i` 6 interleaves the lower-half elements of `dst_i` and `src_i` at the `gran_i` element size. Element k of `dst_i` lands at result position 2k and element k of `src_i` lands at position 2k+1.
- R11: `op_i` 7 does the same as R10 using the upper-half elements of both operands.
- R12: During reset, `result_o` is zero and `done_o` and `illegal_o` are low. Pack operations ignore `gran_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation this cycle |
| op_i | input | 3 | Operation code (see R3 to R11) |
| gran_i | input | 2 | Lane size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| dst_i | input | 64 | Destination operand (shifted, low half of packs, lower slot of unpacks) |
| src_i | input | 64 | Source operand (register count, high half of packs, upper slot of unpacks) |
| imm_i | input | 8 | Immediate shift count |
| use_imm_i | input | 1 | Take the shift count from `imm_i` instead of `src_i` |
| result_o | output | 64 | Registered result |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Unsupported operation and lane-size combination, valid with `done_o` |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath and an 8-bit immediate. With these values every lane size from byte to quadword exists, and the immediate can express counts both below and above every lane width. That puts the count-saturation edges of R4 at 16, 32 and 64 within reach. Register counts with upper bits set in `src_i` test the full-width comparison. Directed pack vectors drive each lane past both saturation limits. Back-to-back random operations compare against an independently written bit-level model.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
   typedef enum logic [2:0] {
      OP_SLL    = 3'd0,
      OP_SRL    = 3'd1,
      OP_SRA    = 3'd2,
      OP_PK_SDW = 3'd3,
      OP_PK_SWB = 3'd4,
      OP_PK_UWB = 3'd5,
      OP_UNP_LO = 3'd6,
      OP_UNP_HI = 3'd7
   } pkr_op_e;

   typedef enum logic [1:0] {
      GR_B = 2'd0,
      GR_W = 2'd1,
      GR_D = 2'd2,
      GR_Q = 2'd3
   } pkr_gran_e;

   typedef enum logic [1:0] {
      PK_SDW = 2'd0,
      PK_SWB = 2'd1,
      PK_UWB = 2'd2
   } pkr_pack_e;
endpackage

// File: rtl/pkr_shift.sv
module pkr_shift #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = 64
) (
   input  logic [1:0]        gran_i,
   input  logic [1:0]        kind_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W-1:0] y_o
);
   localparam int N_SIZES = 3;

   if (DATA_W % 64 != 0) begin : g_bad_w
      $error("pkr_shift: DATA_W must be a multiple of 64");
   end
   if (CNT_W < 7) begin : g_bad_c
      $error("pkr_shift: CNT_W too narrow to express a full-lane count");
   end

   logic [N_SIZES-1:0][DATA_W-1:0] gy;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      localparam int LW   = 16 << g;
      localparam int NL   = DATA_W / LW;
      localparam int SH_W = $clog2(LW);
      logic            over;
      logic [SH_W-1:0] amt;
      assign over = (cnt_i >= CNT_W'(LW));
      assign amt  = cnt_i[SH_W-1:0];
      for (genvar l = 0; l < NL; l++) begin : g_lane
         logic [LW-1:0] lane;
         logic [LW-1:0] res;
         assign lane = a_i[l*LW +: LW];
         always_comb begin
            unique case (kind_i)
               2'd0:    res = over ? '0 : (lane << amt);
               2'd1:    res = over ? '0 : (lane >> amt);
               2'd2:    res = over ? {LW{lane[LW-1]}}
                                   : LW'($signed(lane) >>> amt);
               default: res = '0;
            endcase
         end
         assign gy[g][l*LW +: LW] = res;
      end
   end

   always_comb begin
      unique case (gran_i)
         2'd1:    y_o = gy[0];
         2'd2:    y_o = gy[1];
         2'd3:    y_o = gy[2];
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/pkr_pack.sv
module pkr_pack
   import pkr_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   localparam int HALF = DATA_W / 2;
   localparam int NDW  = DATA_W / 32;
   localparam int NWD  = DATA_W / 16;

   if (DATA_W % 64 != 0) begin : g_bad_w
      $error("pkr_pack: DATA_W must be a multiple of 64");
   end

   function automatic logic [15:0] sat_s16(input logic [31:0] v);
      logic signed [31:0] s;
      s = $signed(v);
      if (s > 32'sd32767)       return 16'h7FFF;
      else if (s < -32'sd32768) return 16'h8000;
      else                      return v[15:0];
   endfunction

   function automatic logic [7:0] sat_s8(input logic [15:0] v);
      logic signed [15:0] s;
      s = $signed(v);
      if (s > 16'sd127)       return 8'h7F;
      else if (s < -16'sd128) return 8'h80;
      else                    return v[7:0];
   endfunction

   function automatic logic [7:0] sat_u8(input logic [15:0] v);
      if (v[15])              return 8'h00;
      else if (|v[14:8])      return 8'hFF;
      else                    return v[7:0];
   endfunction

   logic [DATA_W-1:0] y_sdw, y_swb, y_uwb;

   for (genvar i = 0; i < NDW; i++) begin : g_dw
      assign y_sdw[i*16 +: 16]        = sat_s16(a_i[i*32 +: 32]);
      assign y_sdw[HALF + i*16 +: 16] = sat_s16(b_i[i*32 +: 32]);
   end

   for (genvar i = 0; i < NWD; i++) begin : g_wd
      assign y_swb[i*8 +: 8]        = sat_s8(a_i[i*16 +: 16]);
      assign y_swb[HALF + i*8 +: 8] = sat_s8(b_i[i*16 +: 16]);
      assign y_uwb[i*8 +: 8]        = sat_u8(a_i[i*16 +: 16]);
      assign y_uwb[HALF + i*8 +: 8] = sat_u8(b_i[i*16 +: 16]);
   end

   always_comb begin
      unique case (mode_i)
         PK_SDW:  y_o = y_sdw;
         PK_SWB:  y_o = y_swb;
         PK_UWB:  y_o = y_uwb;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/pkr_unpack.sv
module pkr_unpack #(
   parameter int DATA_W = 64
) (
   input  logic [1:0]        gran_i,
   input  logic              hi_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   localparam int HALF    = DATA_W / 2;
   localparam int N_SIZES = 3;

   if (DATA_W % 64 != 0) begin : g_bad_w
      $error("pkr_unpack: DATA_W must be a multiple of 64");
   end

   logic [HALF-1:0] ah, bh;
   assign ah = hi_i ? a_i[DATA_W-1:HALF] : a_i[HALF-1:0];
   assign bh = hi_i ? b_i[DATA_W-1:HALF] : b_i[HALF-1:0];

   logic [N_SIZES-1:0][DATA_W-1:0] gy;

   for (genvar g = 0; g < N_SIZES; g++) begin : g_size
      localparam int EW = 8 << g;
      localparam int NP = HALF / EW;
      for (genvar k = 0; k < NP; k++) begin : g_pair
         assign gy[g][(2*k)*EW   +: EW] = ah[k*EW +: EW];
         assign gy[g][(2*k+1)*EW +: EW] = bh[k*EW +: EW];
      end
   end

   always_comb begin
      unique case (gran_i)
         2'd0:    y_o = gy[0];
         2'd1:    y_o = gy[1];
         2'd2:    y_o = gy[2];
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/pkrearr_unit.sv
module pkrearr_unit
   import pkr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [1:0]        gran_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o,
   output logic              illegal_o
);
   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("pkrearr_unit: IMM_W wider than DATA_W");
   end

   logic [DATA_W-1:0] count;
   logic [DATA_W-1:0] y_shift, y_pack, y_unpack;
   logic [1:0]        pack_mode;
   logic              legal;
   logic [DATA_W-1:0] nxt;

   assign count = use_imm_i ? DATA_W'(imm_i) : src_i;

   always_comb begin
      unique case (op_i)
         OP_PK_SWB: pack_mode = PK_SWB;
         OP_PK_UWB: pack_mode = PK_UWB;
         default:   pack_mode = PK_SDW;
      endcase
   end

   pkr_shift #(.DATA_W(DATA_W), .CNT_W(DATA_W)) u_shift (
      .gran_i (gran_i),
      .kind_i (op_i[1:0]),
      .a_i    (dst_i),
      .cnt_i  (count),
      .y_o    (y_shift)
   );

   pkr_pack #(.DATA_W(DATA_W)) u_pack (
      .mode_i (pack_mode),
      .a_i    (dst_i),
      .b_i    (src_i),
      .y_o    (y_pack)
   );

   pkr_unpack #(.DATA_W(DATA_W)) u_unpack (
      .gran_i (gran_i),
      .hi_i   (op_i == OP_UNP_HI),
      .a_i    (dst_i),
      .b_i    (src_i),
      .y_o    (y_unpack)
   );

   always_comb begin
      legal = 1'b1;
      nxt   = '0;
      unique case (op_i)
         OP_SLL, OP_SRL: begin
            legal = (gran_i != GR_B);
            nxt   = y_shift;
         end
         OP_SRA: begin
            legal = (gran_i == GR_W) || (gran_i == GR_D);
            nxt   = y_shift;
         end
         OP_PK_SDW, OP_PK_SWB, OP_PK_UWB: begin
            nxt   = y_pack;
         end
         default: begin
            legal = (gran_i != GR_Q);
            nxt   = y_unpack;
         end
      endcase
      if (!legal) nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o  <= '0;
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         done_o    <= start_i;
         illegal_o <= start_i & ~legal;
         if (start_i) result_o <= nxt;
      end
   end
endmodule

// File: rtl/pkrearr_unit_chk.sv
module pkrearr_unit_chk
   import pkr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        op_i,
   input logic [1:0]        gran_i,
   input logic [DATA_W-1:0] dst_i,
   input logic [DATA_W-1:0] src_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic              use_imm_i,
   input logic [DATA_W-1:0] result_o,
   input logic              done_o,
   input logic              illegal_o
);
   assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!done_o && $stable(result_o)));

   assert_logic_count_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == OP_SRL && use_imm_i && imm_i >= IMM_W'(64))
      |=> (result_o == '0));

   assert_byte_shift_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == OP_SLL && gran_i == GR_B)
      |=> (illegal_o && result_o == '0));

   assert_illegal_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> done_o);
endmodule

bind pkrearr_unit pkrearr_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/pkrearr_unit_tb_top.sv
module pkrearr_unit_tb_top;
   import pkr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  gran_i = '0;
   logic [63:0] dst_i = '0;
   logic [63:0] src_i = '0;
   logic [7:0]  imm_i = '0;
   logic        use_imm_i = 1'b0;
   logic [63:0] result_o;
   logic        done_o;
   logic        illegal_o;

   int n_checks = 0;
   int n_fail   = 0;

   logic [63:0] exp_q [$];
   bit          ill_q [$];
   string       tag_q [$];
   logic [63:0] last_exp = '0;

   always #4 clk = ~clk;

   pkrearr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .gran_i(gran_i), .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i),
      .use_imm_i(use_imm_i), .result_o(result_o), .done_o(done_o),
      .illegal_o(illegal_o)
   );

   function automatic logic [15:0] m_s16(input logic [31:0] v);
      longint x;
      x = longint'($signed(v));
      if (x > 32767) return 16'h7FFF;
      if (x < -32768) return 16'h8000;
      return v[15:0];
   endfunction

   function automatic logic [7:0] m_s8(input logic [15:0] v);
      int x;
      x = int'($signed(v));
      if (x > 127) return 8'h7F;
      if (x < -128) return 8'h80;
      return v[7:0];
   endfunction

   function automatic logic [7:0] m_u8(input logic [15:0] v);
      int x;
      x = int'($signed(v));
      if (x < 0) return 8'h00;
      if (x > 255) return 8'hFF;
      return v[7:0];
   endfunction

   function automatic logic [63:0] ref_model(input logic [2:0] op, input logic [1:0] g,
                                             input logic [63:0] d, input logic [63:0] s,
                                             input logic [63:0] c, output bit ill);
      logic [63:0] r;
      int L;
      int cc;
      r   = '0;
      ill = 1'b0;
      L   = 8 << g;
      if (op <= 3'd2) begin
         if (g == 2'd0 || (op == 3'd2 && g == 2'd3)) ill = 1'b1;
         else begin
            cc = (c >= 64'(L)) ? L : int'(c);
            for (int b = 0; b < 64; b++) begin
               int p;
               int base;
               p    = b % L;
               base = b - p;
               if (op == 3'd0) begin
                  if (p >= cc) r[b] = d[b - cc];
               end else if (p + cc < L) r[b] = d[b + cc];
               else if (op == 3'd2) r[b] = d[base + L - 1];
            end
         end
      end else if (op == 3'd3) begin
         for (int i = 0; i < 2; i++) begin
            r[16*i +: 16]      = m_s16(d[32*i +: 32]);
            r[32 + 16*i +: 16] = m_s16(s[32*i +: 32]);
         end
      end else if (op == 3'd4 || op == 3'd5) begin
         for (int i = 0; i < 4; i++) begin
            r[8*i +: 8]      = (op == 3'd4) ? m_s8(d[16*i +: 16]) : m_u8(d[16*i +: 16]);
            r[32 + 8*i +: 8] = (op == 3'd4) ? m_s8(s[16*i +: 16]) : m_u8(s[16*i +: 16]);
         end
      end else begin
         if (g == 2'd3) ill = 1'b1;
         else begin
            for (int b = 0; b < 64; b++) begin
               int idx;
               int p;
               int hf;
               idx = b / L;
               p   = b % L;
               hf  = (op == 3'd7) ? 32 : 0;
               if (idx % 2 == 1) r[b] = s[hf + (idx/2)*L + p];
               else              r[b] = d[hf + (idx/2)*L + p];
            end
         end
      end
      return r;
   endfunction

   task automatic send(input logic [2:0] op, input logic [1:0] g, input logic [63:0] d,
                       input logic [63:0] s, input logic [7:0] imm, input logic ui,
                       input logic [63:0] exp_r, input bit exp_ill, input string tag);
      exp_q.push_back(exp_r);
      ill_q.push_back(exp_ill);
      tag_q.push_back(tag);
      last_exp = exp_r;
      @(negedge clk);
      op_i = op; gran_i = g; dst_i = d; src_i = s; imm_i = imm; use_imm_i = ui;
      start_i = 1'b1;
   endtask

   task automatic send_m(input logic [2:0] op, input logic [1:0] g, input logic [63:0] d,
                         input logic [63:0] s, input logic [7:0] imm, input logic ui,
                         input string tag);
      logic [63:0] e;
      bit il;
      e = ref_model(op, g, d, s, ui ? {56'd0, imm} : s, il);
      send(op, g, d, s, imm, ui, e, il, tag);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      start_i = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: scoreboard comparison on each completion pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R1: unexpected done, actual result %h expected no completion", result_o);
         end else begin
            logic [63:0] e;
            bit il;
            string t;
            e  = exp_q.pop_front();
            il = ill_q.pop_front();
            t  = tag_q.pop_front();
            if (result_o !== e || illegal_o !== il) begin
               n_fail++;
               $display("FAIL %s: actual %h ill=%0b expected %h ill=%0b",
                        t, result_o, illegal_o, e, il);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_checks++;
      if (result_o !== '0 || done_o !== 1'b0 || illegal_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R12: actual %h/%0b/%0b expected 0/0/0", result_o, done_o, illegal_o);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: word logical left by immediate 4
      send(3'd0, 2'd1, 64'h8001_7FFF_0F0F_1234, 64'hFFFF, 8'd4, 1'b1,
           64'h0010_FFF0_F0F0_2340, 1'b0, "R3 sll word imm");
      // R3: quad logical right by register count
      send_m(3'd1, 2'd3, 64'hF000_0000_0000_0001, 64'd60, 8'd0, 1'b0, "R3 srl quad reg");
      // R4: logical right with huge register count -> zero
      send(3'd1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 8'd0, 1'b0,
           64'h0, 1'b0, "R4 srl quad huge");
      // R4: arithmetic dword with count 40 -> sign fill
      send(3'd2, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'd40, 8'd0, 1'b0,
           64'hFFFF_FFFF_0000_0000, 1'b0, "R4 sra dword over");
      // R4: word shift count exactly 16 gives zero
      send(3'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd16, 1'b1,
           64'h0, 1'b0, "R4 sll word at width");
      // R5: arithmetic word by 3
      send_m(3'd2, 2'd1, 64'h8000_7FF0_F00F_0123, 64'h0, 8'd3, 1'b1, "R5 sra word");
      // R6: illegal combinations
      send(3'd0, 2'd0, 64'h1234, 64'h0, 8'd1, 1'b1, 64'h0, 1'b1, "R6 sll byte");
      send(3'd2, 2'd3, 64'h1234, 64'h0, 8'd1, 1'b1, 64'h0, 1'b1, "R6 sra quad");
      send(3'd6, 2'd3, 64'h1234, 64'h5678, 8'd0, 1'b0, 64'h0, 1'b1, "R6 unpack quad");
      // R7: dword to word signed saturation
      send(3'd3, 2'd0, 64'h0001_1170_FFFF_FFFB, 64'hFFFF_63C0_0000_007B, 8'd0, 1'b0,
           64'h8000_007B_7FFF_FFFB, 1'b0, "R7 pack sdw");
      // R8: word to signed byte (gran ignored: R12)
      send(3'd4, 2'd3, 64'h0100_FFFF_00FF_0080, 64'h7FFF_8000_0001_0000, 8'd0, 1'b0,
           64'h7F80_0100_7FFF_7F7F, 1'b0, "R8 pack swb");
      // R9: word to unsigned byte
      send(3'd5, 2'd1, 64'h0100_FFFF_00FF_0080, 64'h7FFF_8000_0001_0000, 8'd0, 1'b0,
           64'hFF00_0100_FF00_FF80, 1'b0, "R9 pack uwb");
      // R10: unpack low bytes
      send(3'd6, 2'd0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, 8'd0, 1'b0,
           64'h1303_1202_1101_1000, 1'b0, "R10 unpack lo byte");
      // R11: unpack high words
      send(3'd7, 2'd1, 64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA, 8'd0, 1'b0,
           64'hDDDD_4444_CCCC_3333, 1'b0, "R11 unpack hi word");
      send_m(3'd7, 2'd2, 64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA, 8'd0, 1'b0,
             "R11 unpack hi dword");
      idle(4);

      // R2: result held while idle
      n_checks++;
      if (result_o !== last_exp || done_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R2: actual %h done=%0b expected %h done=0", result_o, done_o, last_exp);
      end

      // R1: back-to-back random operations against the model
      for (int i = 0; i < 400; i++) begin
         logic [63:0] d, s;
         logic [7:0]  im;
         d  = {$urandom, $urandom};
         s  = {$urandom, $urandom};
         im = 8'($urandom_range(0, 80));
         if (i % 3 == 0) s = 64'($urandom_range(0, 70));
         send_m(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), d, s, im,
                1'($urandom_range(0, 1)), "R1 random b2b");
      end
      idle(4);

      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R1: actual %0d pending results expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule